// File: doc/BRIEF.md
# Dual-Channel DAC Register Controller

This block is the digital front end of a two-channel, 10-bit digital-to-analog converter. It listens on a two-wire serial bus as a slave and answers to a 7-bit address. The upper four address bits come from a rewritable configuration register, and the lower three come from strap pins. Commands sent to it load, preset, recall or power down the two working code registers. Each command can act on one channel or on both channels in tandem. The working registers drive the converter codes directly.

Each channel also has a "nonvolatile" shadow register, modelled as flip-flops that take parameter values at reset. The configuration register is modelled the same way. Writes to the shadows and to the configuration are held as pending and are committed only when a stop condition closes the transfer. A new start condition throws away anything still pending.

Both bus lines are sampled on the system clock through synchronisers. SDA is open-drain: the block reads the line and drives only an output enable that pulls it low.

Top module: `dual_dac_ctrl`

## Requirements
- R1: The address byte after a start must equal {device id, strap_i[2:0], rw} in bits 7:4, 3:1 and 0. On a match the slave pulls SDA low during the ninth SCL clock. Any other address gets no acknowledge and is otherwise ignored.
- R2: Command 0x9 is followed by one data byte, which becomes the configuration: [7:4] device id, [3:2] pin function, [1] channel B power-on source, [0] channel A power-on source (1 = shadow, 0 = mid scale). The new value takes effect only at the stop condition.
- R3: A start that arrives before a stop cancels all pending shadow and configuration writes.
- R4: Command byte layout: opcode in [7:4], channel field in [3:2] (01 = A, 10 = B, 11 = both, 00 = none). Opcode 0x1 writes the working register(s) with {cmd[1:0], data byte}. The new value is visible as soon as the data byte has been received, and the data byte is acknowledged.
- R5: Opcode 0x2 writes the shadow register(s) with {cmd[1:0], data byte}. It leaves the working registers unchanged, and the new shadow value can be observed through a later recall.
- R6: Opcode 0x3 writes the working register(s) at once and writes the shadow register(s) at the stop condition.
- R7: Two-byte opcodes 0x4, 0x5 and 0x6 load 0x000, 0x3FF and 0x200 into the selected working registers.
- R8: Opcode 0x7 copies each selected shadow register into its working register.
- R9: Opcode 0x8 sets the power-down flag of each selected channel and leaves its code unchanged. A later write, preset or recall on that channel clears the flag.
- R10: At reset each working register loads its shadow value or 0x200, as chosen by the power-on bit of the reset configuration. Both power-down flags clear and the device id returns to its reset value (0x5 by default).
- R11: Opcode 0xA, and any command with a nonzero channel field, selects the channel to be read: B only for field 10, otherwise A. A read transfer returns {6'b0, code[9:8]} and then code[7:0], alternating for as long as the master acknowledges, and stops at a NACK. SDA changes only while SCL is low.
- R12: Opcodes 0x0 and 0xB–0xF are not acknowledged and change nothing.
- R13: pin_func_o presents the committed pin-function field of the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as read back |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| strap_i | input | 3 | Low three address bits |
| code_a_o | output | 10 | Channel A converter code |
| code_b_o | output | 10 | Channel B converter code |
| pd_a_o | output | 1 | Channel A power-down flag |
| pd_b_o | output | 1 | Channel B power-down flag |
| pin_func_o | output | 2 | Committed multipurpose-pin function |

## Verification
The bench builds the block with a reset configuration of 0x52. That value leaves channel A starting at mid scale and makes channel B start from its shadow value of 0x155, so both power-on sources are seen in a single reset. The shadow reset value for A is set to 0x0AA, and two synchroniser stages are used. With the straps tied to 101, the address fields can be told apart from the device id, and rewriting the id to 0x6 shows the old address stop answering.

// File: rtl/dacctl_pkg.sv
// Package: shared encodings for the dual DAC register controller.
// Assumes a 10-bit code split as two command bits plus one data byte.
package dacctl_pkg;
    localparam int DAC_W = 10;
    localparam int CFG_W = 8;

    typedef enum logic [3:0] {
        OP_WR_WORK = 4'h1,
        OP_WR_NV   = 4'h2,
        OP_WR_BOTH = 4'h3,
        OP_ZERO    = 4'h4,
        OP_FULL    = 4'h5,
        OP_MID     = 4'h6,
        OP_RECALL  = 4'h7,
        OP_PWDN    = 4'h8,
        OP_WR_CFG  = 4'h9,
        OP_SEL_RD  = 4'hA
    } op_e;

    typedef enum logic [2:0] {LS_IDLE, LS_ADDR, LS_CMD, LS_DATA, LS_READ} link_st_e;

    typedef struct packed {
        logic [3:0] dev_id;
        logic [1:0] pin_func;
        logic       por_nv_b;
        logic       por_nv_a;
    } cfg_t;
endpackage

// File: rtl/dacctl_cond.sv
// Bus conditioner: synchronises SCL/SDA to clk and flags edges plus
// start/stop conditions. Assumes bus levels hold for several clk cycles.
module dacctl_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_p,
    output logic stop_p
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d;
    logic scl_s;

    // Synchroniser chains and one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign scl_s    = scl_sh[SYNC_STAGES-1];
    assign sda_s    = sda_sh[SYNC_STAGES-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/dacctl_link.sv
// Link engine: bit/byte framing, address match, acknowledge and read
// shifting. Emits one-cycle pulses for a valid command byte and a data
// byte. Assumes SCL edges arrive as clean single-cycle pulses.
module dacctl_link
    import dacctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_s,
    input  logic             start_p,
    input  logic             stop_p,
    input  logic [3:0]       dev_id,
    input  logic [2:0]       strap,
    input  logic [DAC_W-1:0] rd_word,
    output logic             sda_oe,
    output logic             cmd_p,
    output logic             data_p,
    output logic [7:0]       rx_byte
);
    localparam int HI_PAD = 16 - DAC_W;

    link_st_e   st_q;
    logic [6:0] sh_q, tx_q;
    logic [3:0] bit_q;
    logic       in_ack_q, ack_q, done_q, mack_q, hi_q;

    wire       last_bit = scl_rise && !in_ack_q && bit_q == 4'd7;
    wire       addr_hit = rx_byte[7:1] == {dev_id, strap};
    wire [3:0] opc      = rx_byte[7:4];
    wire       op_ok    = opc >= 4'h1 && opc <= 4'hA;
    wire       op_long  = opc inside {OP_WR_WORK, OP_WR_NV, OP_WR_BOTH, OP_WR_CFG};
    wire [7:0] tx_next  = hi_q ? {{HI_PAD{1'b0}}, rd_word[DAC_W-1:8]} : rd_word[7:0];

    assign rx_byte = {sh_q, sda_s};
    assign cmd_p   = last_bit && st_q == LS_CMD && op_ok;
    assign data_p  = last_bit && st_q == LS_DATA;

    // Protocol state, bit counting, acknowledge and read-bit driving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= LS_IDLE; sh_q <= '0; tx_q <= '0; bit_q <= '0;
            in_ack_q <= 1'b0; ack_q <= 1'b0; done_q <= 1'b0;
            mack_q <= 1'b0; hi_q <= 1'b1; sda_oe <= 1'b0;
        end else if (start_p) begin
            st_q <= LS_ADDR; bit_q <= '0; in_ack_q <= 1'b0;
            done_q <= 1'b0; hi_q <= 1'b1; sda_oe <= 1'b0;
        end else if (stop_p) begin
            st_q <= LS_IDLE; in_ack_q <= 1'b0; done_q <= 1'b0; sda_oe <= 1'b0;
        end else begin
            if (scl_rise) begin
                if (in_ack_q) begin
                    mack_q <= !sda_s;
                end else if (st_q != LS_IDLE) begin
                    sh_q  <= rx_byte[6:0];
                    bit_q <= bit_q + 4'd1;
                    if (bit_q == 4'd7) begin
                        done_q <= 1'b1;
                        case (st_q)
                            LS_ADDR: begin
                                ack_q <= addr_hit;
                                st_q  <= !addr_hit ? LS_IDLE : (rx_byte[0] ? LS_READ : LS_CMD);
                            end
                            LS_CMD: begin
                                ack_q <= op_ok;
                                st_q  <= (op_ok && op_long) ? LS_DATA : LS_IDLE;
                            end
                            LS_DATA: begin
                                ack_q <= 1'b1;
                                st_q  <= LS_IDLE;
                            end
                            default: ack_q <= 1'b0;
                        endcase
                    end
                end
            end
            if (scl_fall) begin
                if (done_q) begin
                    done_q   <= 1'b0;
                    in_ack_q <= 1'b1;
                    sda_oe   <= ack_q;
                end else if (in_ack_q) begin
                    in_ack_q <= 1'b0;
                    bit_q    <= '0;
                    if (st_q == LS_READ && mack_q) begin
                        tx_q   <= tx_next[6:0];
                        sda_oe <= !tx_next[7];
                        hi_q   <= !hi_q;
                    end else begin
                        sda_oe <= 1'b0;
                        if (st_q == LS_READ) st_q <= LS_IDLE;
                    end
                end else if (st_q == LS_READ && bit_q != 4'd0) begin
                    sda_oe <= !tx_q[6];
                    tx_q   <= {tx_q[5:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/dacctl_regs.sv
// Register bank: working codes, shadows, power-down flags and configuration.
// Shadow and configuration writes stay pending until a stop and are
// dropped on a start. Assumes cmd_p/data_p are single-cycle pulses.
module dacctl_regs
    import dacctl_pkg::*;
#(
    parameter logic [DAC_W-1:0] NV_INIT_A = '0,
    parameter logic [DAC_W-1:0] NV_INIT_B = '0,
    parameter logic [CFG_W-1:0] CFG_INIT  = 8'h50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_p,
    input  logic             data_p,
    input  logic [7:0]       rx_byte,
    input  logic             start_p,
    input  logic             stop_p,
    output logic [DAC_W-1:0] code_a,
    output logic [DAC_W-1:0] code_b,
    output logic [1:0]       pd,
    output logic [DAC_W-1:0] rd_word,
    output cfg_t             cfg
);
    localparam cfg_t             CI   = cfg_t'(CFG_INIT);
    localparam logic [DAC_W-1:0] MIDV = 1 << (DAC_W - 1);

    logic [7:0]       cmd_q;
    logic [1:0]       pend_q;
    logic [DAC_W-1:0] pend_val_q;
    logic             cfg_pend_q, sel_q;
    cfg_t             cfg_val_q;

    wire op_e         cmd_op   = op_e'(rx_byte[7:4]);
    wire op_e         dat_op   = op_e'(cmd_q[7:4]);
    wire [1:0]        cmd_mask = rx_byte[3:2];
    wire [1:0]        dat_mask = cmd_q[3:2];
    wire [DAC_W-1:0]  dat_val  = {cmd_q[1:0], rx_byte};
    wire              wr_work  = data_p && (dat_op == OP_WR_WORK || dat_op == OP_WR_BOTH);

    // Per-channel working code, shadow and power-down flag.
    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        localparam logic [DAC_W-1:0] NVI = ch ? NV_INIT_B : NV_INIT_A;
        localparam logic             PON = ch ? CI.por_nv_b : CI.por_nv_a;
        logic [DAC_W-1:0] work, nv;
        logic             pdf;

        // Execute commands addressed to this channel; commit shadow on stop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                work <= PON ? NVI : MIDV;
                nv   <= NVI;
                pdf  <= 1'b0;
            end else begin
                if (cmd_p && cmd_mask[ch]) begin
                    case (cmd_op)
                        OP_ZERO:   begin work <= '0;   pdf <= 1'b0; end
                        OP_FULL:   begin work <= '1;   pdf <= 1'b0; end
                        OP_MID:    begin work <= MIDV; pdf <= 1'b0; end
                        OP_RECALL: begin work <= nv;   pdf <= 1'b0; end
                        OP_PWDN:   pdf <= 1'b1;
                        default:   ;
                    endcase
                end
                if (wr_work && dat_mask[ch]) begin
                    work <= dat_val;
                    pdf  <= 1'b0;
                end
                if (stop_p && pend_q[ch]) nv <= pend_val_q;
            end
        end
    end

    // Latch the command, track read selection, hold and commit pending writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0; pend_q <= '0; pend_val_q <= '0;
            cfg_pend_q <= 1'b0; cfg_val_q <= CI; cfg <= CI; sel_q <= 1'b0;
        end else if (start_p) begin
            pend_q <= '0; cfg_pend_q <= 1'b0;
        end else if (stop_p) begin
            if (cfg_pend_q) cfg <= cfg_val_q;
            pend_q <= '0; cfg_pend_q <= 1'b0;
        end else begin
            if (cmd_p) begin
                cmd_q <= rx_byte;
                if (cmd_mask != 2'b00) sel_q <= (cmd_mask == 2'b10);
            end
            if (data_p && (dat_op == OP_WR_NV || dat_op == OP_WR_BOTH)) begin
                pend_q     <= pend_q | dat_mask;
                pend_val_q <= dat_val;
            end
            if (data_p && dat_op == OP_WR_CFG) begin
                cfg_pend_q <= 1'b1;
                cfg_val_q  <= cfg_t'(rx_byte);
            end
        end
    end

    assign code_a  = g_ch[0].work;
    assign code_b  = g_ch[1].work;
    assign pd      = {g_ch[1].pdf, g_ch[0].pdf};
    assign rd_word = sel_q ? g_ch[1].work : g_ch[0].work;
endmodule

// File: rtl/dual_dac_ctrl.sv
// Top: two-wire slave controlling a dual 10-bit DAC register set.
// Assumes clk is several times faster than SCL; SDA is open-drain.
module dual_dac_ctrl
    import dacctl_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [DAC_W-1:0] NV_INIT_A   = 10'h000,
    parameter logic [DAC_W-1:0] NV_INIT_B   = 10'h000,
    parameter logic [CFG_W-1:0] CFG_INIT    = 8'h50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic [2:0]       strap_i,
    output logic [DAC_W-1:0] code_a_o,
    output logic [DAC_W-1:0] code_b_o,
    output logic             pd_a_o,
    output logic             pd_b_o,
    output logic [1:0]       pin_func_o
);
    logic scl_rise, scl_fall, sda_s, start_p, stop_p, cmd_p, data_p;
    logic [7:0]       rx_byte;
    logic [DAC_W-1:0] rd_word;
    logic [1:0]       pd;
    cfg_t             cfg;

    dacctl_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .start_p(start_p), .stop_p(stop_p)
    );

    dacctl_link u_link (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p),
        .dev_id(cfg.dev_id), .strap(strap_i), .rd_word(rd_word),
        .sda_oe(sda_oe_o), .cmd_p(cmd_p), .data_p(data_p), .rx_byte(rx_byte)
    );

    dacctl_regs #(.NV_INIT_A(NV_INIT_A), .NV_INIT_B(NV_INIT_B), .CFG_INIT(CFG_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_p(cmd_p), .data_p(data_p), .rx_byte(rx_byte),
        .start_p(start_p), .stop_p(stop_p), .code_a(code_a_o), .code_b(code_b_o),
        .pd(pd), .rd_word(rd_word), .cfg(cfg)
    );

    assign pd_a_o     = pd[0];
    assign pd_b_o     = pd[1];
    assign pin_func_o = cfg.pin_func;
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
// Checker: port-level timing rules of the controller, bound to the top.
module dual_dac_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_i,
    input logic       sda_oe_o,
    input logic [9:0] code_a_o,
    input logic [9:0] code_b_o,
    input logic       pd_a_o,
    input logic       pd_b_o,
    input logic [1:0] pin_func_o
);
    // R11: slave moves SDA only while SCL is low.
    a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);
    // R4: working codes update only after a bit sampled with SCL high.
    a_r4_code_a_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (code_a_o != $past(code_a_o)) |-> scl_i);
    a_r4_code_b_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (code_b_o != $past(code_b_o)) |-> scl_i);
    // R9: entering power-down leaves the code untouched.
    a_r9_pd_a_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_a_o) |-> $stable(code_a_o));
    a_r9_pd_b_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_b_o) |-> $stable(code_b_o));
    // R2: configuration changes only at a stop (both lines high).
    a_r2_cfg_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_func_o != $past(pin_func_o)) |-> (scl_i && sda_i));
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe_o(sda_oe_o),
    .code_a_o(code_a_o), .code_b_o(code_b_o), .pd_a_o(pd_a_o), .pd_b_o(pd_b_o),
    .pin_func_o(pin_func_o)
);

// File: tb/tb_dual_dac_ctrl.sv
module tb_dual_dac_ctrl;
    localparam int Q = 10;
    localparam int NV = 17;
    // {cmd, data, long, cmd_ack, exp_a, exp_b, exp_pd{b,a}}
    localparam logic [39:0] VEC [NV] = '{
        {8'h16, 8'hAB, 1'b1, 1'b1, 10'h2AB, 10'h155, 2'b00},  // R4 A
        {8'h18, 8'hF0, 1'b1, 1'b1, 10'h2AB, 10'h0F0, 2'b00},  // R4 B
        {8'h1F, 8'hFF, 1'b1, 1'b1, 10'h3FF, 10'h3FF, 2'b00},  // R4 both
        {8'h4C, 8'h00, 1'b0, 1'b1, 10'h000, 10'h000, 2'b00},  // R7 zero
        {8'h54, 8'h00, 1'b0, 1'b1, 10'h3FF, 10'h000, 2'b00},  // R7 full
        {8'h68, 8'h00, 1'b0, 1'b1, 10'h3FF, 10'h200, 2'b00},  // R7 mid
        {8'h8C, 8'h00, 1'b0, 1'b1, 10'h3FF, 10'h200, 2'b11},  // R9 pd
        {8'h44, 8'h00, 1'b0, 1'b1, 10'h000, 10'h200, 2'b10},  // R9 clear
        {8'h25, 8'h23, 1'b1, 1'b1, 10'h000, 10'h200, 2'b10},  // R5 nv
        {8'h74, 8'h00, 1'b0, 1'b1, 10'h123, 10'h200, 2'b10},  // R8 recall
        {8'h78, 8'h00, 1'b0, 1'b1, 10'h123, 10'h155, 2'b00},  // R8 B
        {8'h3A, 8'h34, 1'b1, 1'b1, 10'h123, 10'h234, 2'b00},  // R6
        {8'h64, 8'h00, 1'b0, 1'b1, 10'h200, 10'h234, 2'b00},  // R7
        {8'h78, 8'h00, 1'b0, 1'b1, 10'h200, 10'h234, 2'b00},  // R6 nv
        {8'hB4, 8'h00, 1'b0, 1'b0, 10'h200, 10'h234, 2'b00},  // R12
        {8'h04, 8'h00, 1'b0, 1'b0, 10'h200, 10'h234, 2'b00},  // R12
        {8'h40, 8'h00, 1'b0, 1'b1, 10'h200, 10'h234, 2'b00}   // R4 none
    };

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
    logic [2:0] strap = 3'b101;
    logic sda_oe, pd_a, pd_b;
    logic [9:0] code_a, code_b;
    logic [1:0] pin_func;
    wire  sda = ~(m_low | sda_oe);
    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic ack;
    logic [7:0] rb;

    always #5 clk = ~clk;

    dual_dac_ctrl #(.SYNC_STAGES(2), .NV_INIT_A(10'h0AA), .NV_INIT_B(10'h155), .CFG_INIT(8'h52)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(sda_oe),
        .strap_i(strap), .code_a_o(code_a), .code_b_o(code_b), .pd_a_o(pd_a),
        .pd_b_o(pd_b), .pin_func_o(pin_func)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic qw; repeat (Q) @(negedge clk); endtask
    task automatic bus_start; m_low = 0; qw(); scl = 1; qw(); m_low = 1; qw(); scl = 0; qw(); endtask
    task automatic bus_stop;  m_low = 1; qw(); scl = 1; qw(); m_low = 0; qw(); qw(); endtask

    task automatic wr_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; qw(); scl = 1; qw(); qw(); scl = 0; qw();
        end
        m_low = 0; qw(); scl = 1; qw(); a = ~sda; qw(); scl = 0; qw();
    endtask

    task automatic rd_byte(input bit nack, output logic [7:0] b);
        m_low = 0;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl = 1; qw(); b[i] = sda; qw(); scl = 0; qw();
        end
        m_low = ~nack; qw(); scl = 1; qw(); qw(); scl = 0; qw(); m_low = 0;
    endtask

    task automatic cmd2(input logic [7:0] c);
        bus_start(); wr_byte(8'h5A, ack); wr_byte(c, ack); bus_stop();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1; qw();
        chk("R10 reset A", code_a, 10'h200);
        chk("R10 reset B", code_b, 10'h155);
        chk("R10 reset pd", {pd_b, pd_a}, 0);
        chk("R13 reset pin", pin_func, 0);
        chk("R1 idle oe", sda_oe, 0);

        for (int v = 0; v < NV; v++) begin
            bus_start();
            wr_byte(8'h5A, ack); chk("R1 addr ack", ack, 1);
            wr_byte(VEC[v][39:32], ack); chk("R12 cmd ack", ack, VEC[v][22]);
            if (VEC[v][23]) begin wr_byte(VEC[v][31:24], ack); chk("R4 data ack", ack, 1); end
            bus_stop();
            chk("R4/R7/R8 code A", code_a, VEC[v][21:12]);
            chk("R4/R7/R8 code B", code_b, VEC[v][11:2]);
            chk("R9 pd", {pd_b, pd_a}, VEC[v][1:0]);
        end

        // R11 read B then A with wrap
        cmd2(8'hA8);
        bus_start(); wr_byte(8'h5B, ack); chk("R11 rd addr ack", ack, 1);
        rd_byte(0, rb); chk("R11 B hi", rb, 8'h02);
        rd_byte(1, rb); chk("R11 B lo", rb, 8'h34);
        bus_stop();
        chk("R11 released", sda_oe, 0);
        cmd2(8'hA4);
        bus_start(); wr_byte(8'h5B, ack);
        rd_byte(0, rb); chk("R11 A hi", rb, 8'h02);
        rd_byte(0, rb); chk("R11 A lo", rb, 8'h00);
        rd_byte(1, rb); chk("R11 A wrap", rb, 8'h02);
        bus_stop();

        // R3 abort discards pending shadow write
        bus_start(); wr_byte(8'h5A, ack); wr_byte(8'h27, ack); wr_byte(8'hFF, ack);
        bus_start(); wr_byte(8'h5A, ack); wr_byte(8'h74, ack); bus_stop();
        chk("R3 abort keeps shadow", code_a, 10'h123);

        // R1 mismatches
        bus_start(); wr_byte(8'h56, ack); bus_stop(); chk("R1 bad strap", ack, 0);
        bus_start(); wr_byte(8'h6A, ack); bus_stop(); chk("R1 bad id", ack, 0);

        // R2 / R13 configuration commit at stop
        bus_start(); wr_byte(8'h5A, ack); wr_byte(8'h90, ack); wr_byte(8'h6C, ack);
        chk("R2 cfg ack", ack, 1);
        chk("R2 before stop", pin_func, 0);
        bus_stop();
        chk("R13 pin func", pin_func, 2'b11);
        bus_start(); wr_byte(8'h5A, ack); bus_stop(); chk("R2 old id", ack, 0);
        bus_start(); wr_byte(8'h6A, ack); bus_stop(); chk("R2 new id", ack, 1);

        // R10 reset again
        rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; qw();
        chk("R10 re-reset A", code_a, 10'h200);
        chk("R10 re-reset B", code_b, 10'h155);
        chk("R10 re-reset pin", pin_func, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule